// File: doc/BRIEF.md
# Multi-Level Page Table Walker

This block turns a virtual address into a physical address by reading a three-level radix page table out of memory, one entry per level. A requester hands it a virtual address, the kind of access (instruction fetch, load or store), the current privilege level and a handful of status fields. The walker settles the privilege that really applies, checks that the address is canonical, and then reads page-table entries through a single-outstanding read port. It finishes with a one-cycle completion pulse carrying either the physical address or a fault flag, along with the access kind that was requested.

Status fields are captured when the request is accepted, so they may change while a walk is in flight. Machine-mode and untranslated accesses never touch memory. Each table read address is checked against the memory window before it is issued.

Top module: `page_walker`

## Requirements
- R1: The effective privilege of a fetch is always `cur_priv`. For a load or store with `st_mprv` set, it is `st_mpp`; with `st_mprv` clear, it is `cur_priv`. Privilege codes: 0 user, 1 supervisor, 3 machine. Access codes: 0 fetch, 1 load, 2 store.
- R2: When `st_pum` is set and a load or store has effective supervisor privilege, a leaf with its U bit set faults. Fetches and loads or stores at any other privilege ignore `st_pum`.
- R3: When `st_vm` is 0, or the effective privilege is machine, no table read is made. The `done` pulse comes in the cycle after acceptance, with `done_paddr` equal to the 64-bit virtual address and no fault.
- R4: When translation applies, bits 63:38 of the virtual address must be all zeros or all ones. Otherwise the access faults and no table read is made.
- R5: The root table lies at `root_ppn` shifted left by 12. Level L (2, then 1, then 0) reads the address base + VA[12+9L+8 : 12+9L] * 8.
- R6: A table entry has bit 0 as valid, bit 1 as readable, bit 2 as writable, bit 3 as executable and bit 4 as user, with its page number in bits 53:10. A valid entry whose bits 3:1 are all zero points to the next table, whose base is its page number shifted left by 12. An invalid entry faults, and so does a table pointer met at level 0.
- R7: A leaf grants a load only if readable, a store only if writable and a fetch only if executable. At user privilege the leaf must also have U set. Any failed check is a fault.
- R8: When a table-entry address falls outside [MEM_BASE, MEM_BASE+MEM_SIZE), that read is not issued and the access faults.
- R9: A successful walk returns the leaf page number shifted left by 12, OR'ed with VA[11:0].
- R10: `done` is high for exactly one cycle per accepted request, with `done_type` equal to the request's access code. `req_ready` is high only while idle.
- R11: A read request stays asserted with a stable address until `mem_req_ready` is seen. The next read is issued only after the response to the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request accepted |
| req_vaddr | input | 64 | Virtual address |
| req_type | input | 2 | Access kind: 0 fetch, 1 load, 2 store |
| cur_priv | input | 2 | Current privilege level |
| st_mprv | input | 1 | Data accesses use the previous-privilege field |
| st_mpp | input | 2 | Previous-privilege field |
| st_pum | input | 1 | Deny supervisor data access to user pages |
| st_vm | input | 1 | 0 untranslated, 1 three-level paging |
| root_ppn | input | 44 | Page number of the root table |
| mem_req_valid | output | 1 | Table-entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 64 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 64 | Entry contents |
| done | output | 1 | One-cycle completion pulse |
| done_paddr | output | 64 | Physical address (0 on fault) |
| done_fault | output | 1 | Translation failed |
| done_type | output | 2 | Access kind of the finished request |

## Verification
The walk is tried with canonical addresses from both the low half and the sign-extended upper half, which shows that the index slices and the upper-bit check are taken from the correct bits. Leaves with different permission sets are paired with each access kind and privilege, alone and combined with the previous-privilege and user-protect fields, so that a wrong effective-mode choice shows up as a fault or a pass that should not occur. Broken tables (an invalid entry, a pointer at the last level, a pointer leaving the memory window, a root outside it) show where the walk stops, judged by the number of reads. A stalling memory shows that requests are held, and a cycle-latency comparison separates bypass from a full walk.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int XLEN = 64;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2,
    ACC_RSV   = 2'd3
  } acc_t;

  typedef enum logic [1:0] {
    PRIV_U   = 2'd0,
    PRIV_S   = 2'd1,
    PRIV_RSV = 2'd2,
    PRIV_M   = 2'd3
  } priv_t;

  // entry flag positions
  localparam int PTE_V = 0;
  localparam int PTE_R = 1;
  localparam int PTE_W = 2;
  localparam int PTE_X = 3;
  localparam int PTE_U = 4;
  localparam int PTE_PPN_LSB = 10;

  // byte address of the entry selected at a given level
  function automatic logic [XLEN-1:0] pte_slot_addr(
    input logic [XLEN-1:0] base, input logic [XLEN-1:0] va,
    input int lvl, input int pg_shift, input int idx_w, input int pte_bytes);
    logic [XLEN-1:0] idx;
    idx = (va >> (pg_shift + lvl * idx_w)) & ((64'd1 << idx_w) - 64'd1);
    return base + idx * XLEN'(pte_bytes);
  endfunction

  // bits from va_bits-1 upward must be a pure sign extension
  function automatic logic va_canonical(input logic [XLEN-1:0] va, input int va_bits);
    logic [XLEN-1:0] mask;
    logic [XLEN-1:0] hi;
    mask = ~((64'd1 << (va_bits - 1)) - 64'd1);
    hi   = va & mask;
    return (hi == '0) || (hi == mask);
  endfunction

  function automatic logic in_window(input logic [XLEN-1:0] a,
                                     input logic [XLEN-1:0] base,
                                     input logic [XLEN-1:0] size);
    return (a >= base) && ((a - base) < size);
  endfunction

  function automatic logic [XLEN-1:0] join_pa(input logic [XLEN-1:0] page,
                                              input logic [XLEN-1:0] va,
                                              input int pg_shift);
    return (page << pg_shift) | (va & ((64'd1 << pg_shift) - 64'd1));
  endfunction
endpackage

// File: rtl/ptw_mode_sel.sv
module ptw_mode_sel
  import ptw_pkg::*;
(
  input  logic [1:0] acc_type,
  input  logic [1:0] cur_priv,
  input  logic       mprv,
  input  logic [1:0] mpp,
  input  logic       pum,
  input  logic       vm_on,
  output logic [1:0] eff_priv,
  output logic       bypass,
  output logic       protect
);
  logic is_data;
  logic [1:0] chosen;

  always_comb begin
    is_data = (acc_t'(acc_type) != ACC_FETCH);
    chosen  = (is_data && mprv) ? mpp : cur_priv;
    eff_priv = vm_on ? chosen : 2'(PRIV_M);
    bypass   = (priv_t'(eff_priv) == PRIV_M);
    protect  = is_data && pum && (priv_t'(chosen) == PRIV_S);
  end
endmodule

// File: rtl/ptw_perm.sv
module ptw_perm
  import ptw_pkg::*;
(
  input  logic [4:0] flags,
  input  logic [1:0] acc_type,
  input  logic       user_mode,
  input  logic       protect,
  output logic       leaf_ok
);
  logic kind_ok;
  logic owner_ok;

  always_comb begin
    unique case (acc_t'(acc_type))
      ACC_FETCH: kind_ok = flags[PTE_X];
      ACC_LOAD:  kind_ok = flags[PTE_R];
      ACC_STORE: kind_ok = flags[PTE_W];
      default:   kind_ok = 1'b0;
    endcase
    if (user_mode) owner_ok = flags[PTE_U];
    else           owner_ok = !(protect && flags[PTE_U]);
    leaf_ok = flags[PTE_V] && kind_ok && owner_ok;
  end
endmodule

// File: rtl/page_walker.sv
module page_walker
  import ptw_pkg::*;
#(
  parameter int LEVELS    = 3,
  parameter int IDX_W     = 9,
  parameter int PG_SHIFT  = 12,
  parameter int PTE_BYTES = 8,
  parameter int PPN_W     = 44,
  parameter logic [63:0] MEM_BASE = 64'h0000_0000_8000_0000,
  parameter logic [63:0] MEM_SIZE = 64'h0000_0000_0100_0000
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [63:0] req_vaddr,
  input  logic [1:0]  req_type,
  input  logic [1:0]  cur_priv,
  input  logic        st_mprv,
  input  logic [1:0]  st_mpp,
  input  logic        st_pum,
  input  logic        st_vm,
  input  logic [PPN_W-1:0] root_ppn,
  output logic        mem_req_valid,
  input  logic        mem_req_ready,
  output logic [63:0] mem_req_addr,
  input  logic        mem_rsp_valid,
  input  logic [63:0] mem_rsp_data,
  output logic        done,
  output logic [63:0] done_paddr,
  output logic        done_fault,
  output logic [1:0]  done_type
);
  localparam int VA_BITS = PG_SHIFT + LEVELS * IDX_W;
  localparam int LVL_W   = (LEVELS > 1) ? $clog2(LEVELS) : 1;
  localparam int PPN_HI  = PTE_PPN_LSB + PPN_W;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT, S_FIN} st_t;

  st_t              st_q;
  logic [63:0]      va_q, addr_q, pa_q;
  logic             fault_q, user_q, prot_q;
  logic [1:0]       type_q;
  logic [LVL_W-1:0] lvl_q;

  // request-side decisions
  logic [1:0]  eff_priv;
  logic        bypass, protect;
  ptw_mode_sel u_mode (
    .acc_type(req_type), .cur_priv(cur_priv), .mprv(st_mprv), .mpp(st_mpp),
    .pum(st_pum), .vm_on(st_vm), .eff_priv(eff_priv), .bypass(bypass),
    .protect(protect)
  );

  logic        accept_evt, bypass_evt, canon_fail_evt, root_oob_evt;
  logic [63:0] root_base, first_addr;
  assign accept_evt     = req_valid && (st_q == S_IDLE);
  assign root_base      = 64'(root_ppn) << PG_SHIFT;
  assign first_addr     = pte_slot_addr(root_base, req_vaddr, LEVELS - 1, PG_SHIFT, IDX_W, PTE_BYTES);
  assign bypass_evt     = accept_evt && bypass;
  assign canon_fail_evt = accept_evt && !bypass && !va_canonical(req_vaddr, VA_BITS);
  assign root_oob_evt   = accept_evt && !bypass && va_canonical(req_vaddr, VA_BITS)
                          && !in_window(first_addr, MEM_BASE, MEM_SIZE);

  // response-side decisions
  logic [63:0] pte_page, next_base, next_addr;
  logic        pte_valid, pte_table, leaf_ok;
  logic        rsp_evt, walk_down_evt, leaf_pass_evt, prot_hit_evt;
  logic        unused_pte_bits;

  assign pte_page  = 64'(mem_rsp_data[PPN_HI-1:PTE_PPN_LSB]);
  assign pte_valid = mem_rsp_data[PTE_V];
  assign pte_table = pte_valid && !mem_rsp_data[PTE_R] && !mem_rsp_data[PTE_W] && !mem_rsp_data[PTE_X];
  assign next_base = pte_page << PG_SHIFT;
  assign next_addr = pte_slot_addr(next_base, va_q, int'(lvl_q) - 1, PG_SHIFT, IDX_W, PTE_BYTES);
  assign unused_pte_bits = ^{mem_rsp_data[63:PPN_HI], mem_rsp_data[PTE_PPN_LSB-1:PTE_U+1]};

  ptw_perm u_perm (
    .flags(mem_rsp_data[PTE_U:PTE_V]), .acc_type(type_q), .user_mode(user_q),
    .protect(prot_q), .leaf_ok(leaf_ok)
  );

  assign rsp_evt       = (st_q == S_WAIT) && mem_rsp_valid;
  assign walk_down_evt = rsp_evt && pte_table && (lvl_q != '0)
                         && in_window(next_addr, MEM_BASE, MEM_SIZE);
  assign leaf_pass_evt = rsp_evt && pte_valid && !pte_table && leaf_ok;
  assign prot_hit_evt  = rsp_evt && pte_valid && !pte_table && prot_q && mem_rsp_data[PTE_U];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      va_q    <= '0;
      addr_q  <= '0;
      pa_q    <= '0;
      fault_q <= 1'b0;
      user_q  <= 1'b0;
      prot_q  <= 1'b0;
      type_q  <= '0;
      lvl_q   <= '0;
    end else begin
      unique case (st_q)
        S_IDLE: if (accept_evt) begin
          va_q   <= req_vaddr;
          type_q <= req_type;
          user_q <= (priv_t'(eff_priv) == PRIV_U);
          prot_q <= protect;
          lvl_q  <= LVL_W'(LEVELS - 1);
          if (bypass_evt) begin
            pa_q <= req_vaddr; fault_q <= 1'b0; st_q <= S_FIN;
          end else if (canon_fail_evt || root_oob_evt) begin
            pa_q <= '0; fault_q <= 1'b1; st_q <= S_FIN;
          end else begin
            addr_q <= first_addr; st_q <= S_REQ;
          end
        end
        S_REQ: if (mem_req_ready) st_q <= S_WAIT;
        S_WAIT: if (rsp_evt) begin
          if (walk_down_evt) begin
            addr_q <= next_addr;
            lvl_q  <= lvl_q - 1'b1;
            st_q   <= S_REQ;
          end else if (leaf_pass_evt) begin
            pa_q <= join_pa(pte_page, va_q, PG_SHIFT); fault_q <= 1'b0; st_q <= S_FIN;
          end else begin
            pa_q <= '0; fault_q <= 1'b1; st_q <= S_FIN;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign req_ready     = (st_q == S_IDLE);
  assign mem_req_valid = (st_q == S_REQ);
  assign mem_req_addr  = addr_q;
  assign done          = (st_q == S_FIN);
  assign done_paddr    = pa_q;
  assign done_fault    = fault_q;
  assign done_type     = type_q;

  // ---------------- assertions ----------------
  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  assert_read_in_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> in_window(mem_req_addr, MEM_BASE, MEM_SIZE));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && req_ready);

  assert_bypass_result_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bypass_evt |=> done && !done_fault && (done_paddr == $past(req_vaddr)));

  assert_canon_fault_R4: assert property (@(posedge clk) disable iff (!rst_n)
    canon_fail_evt |=> done && done_fault && !mem_req_valid);

  assert_user_protect_R2: assert property (@(posedge clk) disable iff (!rst_n)
    prot_hit_evt |=> done && done_fault);

  assert_no_read_while_waiting_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_ready |=> !mem_req_valid);
endmodule

// File: tb/page_walker_bench.sv
module page_walker_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_vaddr = '0;
  logic [1:0]  req_type = '0;
  logic [1:0]  cur_priv = '0;
  logic        st_mprv = 1'b0;
  logic [1:0]  st_mpp = '0;
  logic        st_pum = 1'b0;
  logic        st_vm = 1'b0;
  logic [43:0] root_ppn = 44'h80000;
  logic        mem_req_valid;
  logic        mem_req_ready;
  logic [63:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic        done;
  logic [63:0] done_paddr;
  logic        done_fault;
  logic [1:0]  done_type;

  page_walker u_page_walker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_type(req_type), .cur_priv(cur_priv),
    .st_mprv(st_mprv), .st_mpp(st_mpp), .st_pum(st_pum), .st_vm(st_vm),
    .root_ppn(root_ppn), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .done(done), .done_paddr(done_paddr), .done_fault(done_fault), .done_type(done_type)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  // ---- memory model: small list of populated entries ----
  logic [63:0] mem_a [8];
  logic [63:0] mem_d [8];
  int          mem_n = 0;
  int          stall_cfg = 0;
  int          wait_cnt = 0;
  int          rd_total = 0;
  logic [63:0] rd_log [64];

  function automatic logic [63:0] lookup(input logic [63:0] a);
    for (int i = 0; i < 8; i++)
      if (i < mem_n && mem_a[i] == a) return mem_d[i];
    return 64'd0;
  endfunction

  assign mem_req_ready = (wait_cnt >= stall_cfg);

  always @(posedge clk) begin
    wait_cnt      <= (mem_req_valid && !mem_req_ready) ? wait_cnt + 1 : 0;
    mem_rsp_valid <= 1'b0;
    if (mem_req_valid && mem_req_ready) begin
      mem_rsp_valid        <= 1'b1;
      mem_rsp_data         <= lookup(mem_req_addr);
      rd_log[rd_total % 64] <= mem_req_addr;
      rd_total             <= rd_total + 1;
    end
  end

  task automatic mem_put(input logic [63:0] a, input logic [63:0] d);
    mem_a[mem_n] = a; mem_d[mem_n] = d; mem_n++;
  endtask

  // flags: V=1 R=2 W=4 X=8 U=16, page number from bit 10
  function automatic logic [63:0] mk_pte(input logic [43:0] ppn, input logic [4:0] fl);
    return {10'd0, ppn, 5'd0, fl};
  endfunction

  function automatic logic [63:0] slot(input logic [63:0] tbl_ppn, input logic [8:0] ix);
    return {tbl_ppn[51:0], 12'h000} + {52'd0, ix, 3'b000};
  endfunction

  // three tables: root 0x80000 -> 0x80001 -> 0x80002 -> leaf
  task automatic map3(input logic [63:0] va, input logic [43:0] leaf_ppn, input logic [4:0] fl);
    mem_n = 0;
    mem_put(slot(64'h80000, va[38:30]), mk_pte(44'h80001, 5'h01));
    mem_put(slot(64'h80001, va[29:21]), mk_pte(44'h80002, 5'h01));
    mem_put(slot(64'h80002, va[20:12]), mk_pte(leaf_ppn, fl));
  endtask

  logic [63:0] r_pa;
  logic        r_fault;
  logic [1:0]  r_type;
  int          r_reads, r_lat, r_first;

  task automatic xl(input logic [63:0] va, input logic [1:0] typ, input logic [1:0] priv,
                    input logic mprv, input logic [1:0] mpp, input logic pum, input logic vm);
    @(negedge clk);
    req_vaddr = va; req_type = typ; cur_priv = priv; st_mprv = mprv;
    st_mpp = mpp; st_pum = pum; st_vm = vm; req_valid = 1'b1;
    r_first = rd_total;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    req_vaddr = ~va; st_pum = ~pum; st_mprv = ~mprv;  // changes after acceptance must not matter
    r_lat = 1;
    while (!done && r_lat < 200) begin
      @(negedge clk);
      r_lat++;
    end
    r_pa = done_paddr; r_fault = done_fault; r_type = done_type;
    r_reads = rd_total - r_first;
  endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---- scenarios ----
  task automatic t_reset();
    @(negedge clk);
    chk("R10 idle ready", 64'(req_ready), 64'd1);
    chk("R10 no done at reset", 64'(done), 64'd0);
    chk("R11 no read at reset", 64'(mem_req_valid), 64'd0);
  endtask

  task automatic t_bare();
    xl(64'hFEDC_BA98_7654_3210, 2'd1, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0);
    chk("R3 bare pa", r_pa, 64'hFEDC_BA98_7654_3210);
    chk("R3 bare fault", 64'(r_fault), 64'd0);
    chk("R3 bare reads", 64'(r_reads), 64'd0);
    chk("R3 bare latency", 64'(r_lat), 64'd1);
    chk("R10 bare type", 64'(r_type), 64'd1);
    // machine privilege with paging on
    xl(64'h0000_0040_0000_1000, 2'd0, 2'd3, 1'b0, 2'd0, 1'b0, 1'b1);
    chk("R3 machine pa", r_pa, 64'h0000_0040_0000_1000);
    chk("R3 machine reads", 64'(r_reads), 64'd0);
  endtask

  task automatic t_walk();
    logic [63:0] va = 64'h0000_0012_3456_7ABC;
    map3(va, 44'h12345, 5'h07);
    xl(va, 2'd1, 2'd1, 1'b0, 2'd0, 1'b0, 1'b1);
    chk("R9 walk pa", r_pa, 64'h1234_5ABC);
    chk("R9 walk fault", 64'(r_fault), 64'd0);
    chk("R5 walk reads", 64'(r_reads), 64'd3);
    chk("R5 level2 addr", rd_log[r_first % 64], 64'h8000_0000 + 64'(va[38:30]) * 8);
    chk("R6 level1 addr", rd_log[(r_first + 1) % 64], 64'h8000_1000 + 64'(va[29:21]) * 8);
    chk("R6 level0 addr", rd_log[(r_first + 2) % 64], 64'h8000_2000 + 64'(va[20:12]) * 8);
    chk("R10 walk latency", 64'(r_lat), 64'd7);
    xl(va, 2'd2, 2'd1, 1'b0, 2'd0, 1'b0, 1'b1);
    chk("R10 store type", 64'(r_type), 64'd2);
    chk("R7 store writable", 64'(r_fault), 64'd0);
  endtask

  task automatic t_perm();
    logic [63:0] va = 64'h0000_0001_0020_3456;
    map3(va, 44'h00777, 5'h03);  // read-only, supervisor page
    xl(va, 2'd2, 2'd1, 1'b0, 2'd0, 1'b0, 1'b1);
    chk("R7 store to read-only", 64'(r_fault), 64'd1);
    chk("R10 faulting type", 64'(r_type), 64'd2);
    chk("R7 fault pa zero", r_pa, 64'd0);
    xl(va, 2'd0, 2'd1, 1'b0, 2'd0, 1'b0, 1'b1);
    chk("R7 fetch non-exec", 64'(r_fault), 64'd1);
    xl(va, 2'd1, 2'd1, 1'b0, 2'd0, 1'b0, 1'b1);
    chk("R7 load readable", r_pa, 64'h0077_7456);
    xl(va, 2'd1, 2'd0, 1'b0, 2'd0, 1'b0, 1'b1);
    chk("R7 user on supervisor page", 64'(r_fault), 64'd1);
  endtask

  task automatic t_mode();
    logic [63:0] va = 64'h0000_0002_0040_0123;
    map3(va, 44'h00ABC, 5'h19);  // V X U
    xl(va, 2'd0, 2'd0, 1'b1, 2'd1, 1'b0, 1'b1);
    chk("R1 fetch keeps current privilege", r_pa, 64'h00AB_C123);
    chk("R1 fetch ok", 64'(r_fault), 64'd0);
    xl(va, 2'd1, 2'd0, 1'b1, 2'd3, 1'b0, 1'b1);
    chk("R1 load with previous=machine bypasses", r_pa, va);
    chk("R1 bypass reads", 64'(r_reads), 64'd0);
    map3(va, 44'h00ABC, 5'h03);  // V R supervisor
    xl(va, 2'd1, 2'd0, 1'b1, 2'd1, 1'b0, 1'b1);
    chk("R1 load as previous=supervisor", r_pa, 64'h00AB_C123);
    xl(va, 2'd1, 2'd0, 1'b0, 2'd1, 1'b0, 1'b1);
    chk("R1 modify bit clear stays user", 64'(r_fault), 64'd1);
  endtask

  task automatic t_protect();
    logic [63:0] va = 64'h0000_0003_0000_5FF0;
    map3(va, 44'h00042, 5'h1B);  // V R X U
    xl(va, 2'd1, 2'd1, 1'b0, 2'd0, 1'b1, 1'b1);
    chk("R2 supervisor load user page protected", 64'(r_fault), 64'd1);
    xl(va, 2'd1, 2'd1, 1'b0, 2'd0, 1'b0, 1'b1);
    chk("R2 protect off allows", r_pa, 64'h0004_2FF0);
    xl(va, 2'd0, 2'd1, 1'b0, 2'd0, 1'b1, 1'b1);
    chk("R2 fetch ignores protect", 64'(r_fault), 64'd0);
    xl(va, 2'd1, 2'd3, 1'b1, 2'd1, 1'b1, 1'b1);
    chk("R2 effective supervisor via previous field", 64'(r_fault), 64'd1);
    xl(va, 2'd1, 2'd0, 1'b0, 2'd0, 1'b1, 1'b1);
    chk("R2 user load ignores protect", r_pa, 64'h0004_2FF0);
  endtask

  task automatic t_canon();
    logic [63:0] hi = 64'hFFFF_FFC0_1234_5678;
    xl(64'h0000_0040_0000_0000, 2'd1, 2'd1, 1'b0, 2'd0, 1'b0, 1'b1);
    chk("R4 mixed upper bits fault", 64'(r_fault), 64'd1);
    chk("R4 no read", 64'(r_reads), 64'd0);
    map3(hi, 44'h00055, 5'h03);
    xl(hi, 2'd1, 2'd1, 1'b0, 2'd0, 1'b0, 1'b1);
    chk("R4 sign-extended address walks", r_pa, 64'h0005_5678);
  endtask

  task automatic t_broken();
    logic [63:0] va = 64'h0000_0000_4060_8000;
    mem_n = 0;
    mem_put(slot(64'h80000, va[38:30]), mk_pte(44'h00010, 5'h01));
    xl(va, 2'd1, 2'd1, 1'b0, 2'd0, 1'b0, 1'b1);
    chk("R8 pointer leaves window", 64'(r_fault), 64'd1);
    chk("R8 reads before stop", 64'(r_reads), 64'd1);
    root_ppn = 44'h00100;
    xl(va, 2'd1, 2'd1, 1'b0, 2'd0, 1'b0, 1'b1);
    chk("R8 root outside window", 64'(r_fault), 64'd1);
    chk("R8 root no read", 64'(r_reads), 64'd0);
    root_ppn = 44'h80000;
    mem_n = 0;
    xl(va, 2'd1, 2'd1, 1'b0, 2'd0, 1'b0, 1'b1);
    chk("R6 invalid entry", 64'(r_fault), 64'd1);
    chk("R6 invalid reads", 64'(r_reads), 64'd1);
    map3(va, 44'h80003, 5'h01);  // pointer at last level
    xl(va, 2'd1, 2'd1, 1'b0, 2'd0, 1'b0, 1'b1);
    chk("R6 pointer at level 0", 64'(r_fault), 64'd1);
    chk("R6 level0 reads", 64'(r_reads), 64'd3);
  endtask

  task automatic t_stall();
    logic [63:0] va = 64'h0000_0012_3456_7ABC;
    map3(va, 44'h0BEEF, 5'h03);
    stall_cfg = 3;
    xl(va, 2'd1, 2'd1, 1'b0, 2'd0, 1'b0, 1'b1);
    stall_cfg = 0;
    chk("R11 stalled walk pa", r_pa, 64'h0BEE_FABC);
    chk("R11 stalled reads", 64'(r_reads), 64'd3);
    chk("R11 stalled latency", 64'(r_lat), 64'd16);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_bare();
    t_walk();
    t_perm();
    t_mode();
    t_protect();
    t_canon();
    t_broken();
    t_stall();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule